// File: doc/BRIEF.md
# Receive FIFO Character Timeout Detector

This block sits beside the receive FIFO of a UART and raises an interrupt request when buffered characters have been left idle for too long. Without it, a few bytes below the FIFO trigger level could stay in the FIFO with nothing to tell the host they are there. The block measures idle time in baud-clock enables, so the window scales with the line rate. The window is four character times, and its length follows the programmed frame format, including a second stop bit when one is selected.

The timer restarts when a character finishes arriving and when the host reads the FIFO. Once the interrupt has fired, a new arriving character no longer restarts the timer. Only a host read, an empty FIFO, or turning the feature off clears the request. When the FIFO is disabled, or the receive-data interrupt enable is clear, the block is in polled operation: it holds its timer at zero and reports no timeout.

Top module: `rxto_top`

## Requirements
- R1: A synchronous active-high `rst` drives `tmo_irq` low on the next clock edge and clears the idle timer.
- R2: The frame length is 1 + (5 + `data_sel`) + `parity_on` + (1 + `stop_two`) bits, where `data_sel` values 0 to 3 select 5 to 8 data bits. The window is WINDOW_CHARS × OVERSAMPLE × frame length baud enables. `tmo_irq` rises on the clock edge that takes in the window-th `baud_en` counted after the last timer restart.
- R3: `tmo_irq` is low one edge after any cycle with `fifo_nonempty` low. While the FIFO is empty the timer stays at zero, so no interrupt can rise from an empty FIFO.
- R4: While `tmo_irq` is low, a cycle with `rx_char_done` high restarts the window from zero.
- R5: A cycle with `host_rd` high restarts the window from zero. This holds even when `baud_en` is high in the same cycle, because the restart wins.
- R6: Once `tmo_irq` is high it stays high while the block is enabled, the FIFO is non-empty and no host read occurs. An `rx_char_done` pulse neither clears it nor restarts the timer.
- R7: A `host_rd` pulse clears `tmo_irq` on the next edge. A full new window must then pass before it rises again.
- R8: While `fifo_en` or `rx_avail_ie` is low, `tmo_irq` is held low and the timer is held at zero. After re-enabling, a full window is needed.
- R9: Only cycles with `baud_en` high advance the timer. Any number of cycles without an enable between two enables does not change the count at which `tmo_irq` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_en | input | 1 | One-cycle enable per oversampled baud tick |
| fifo_en | input | 1 | FIFO mode enabled |
| rx_avail_ie | input | 1 | Receive-data interrupt enable |
| data_sel | input | 2 | Data bits minus five (0..3) |
| parity_on | input | 1 | Parity bit present in the frame |
| stop_two | input | 1 | Two stop bits instead of one |
| fifo_nonempty | input | 1 | Receive FIFO holds at least one character |
| rx_char_done | input | 1 | Pulse when a received character completes |
| host_rd | input | 1 | Pulse when the host reads the receive FIFO |
| tmo_irq | output | 1 | Character timeout interrupt request |

## Verification
The bench builds the block with OVERSAMPLE = 2 and WINDOW_CHARS = 4. This shortens the window to 56 to 96 enables, so all sixteen frame formats can be swept. For each format the bench checks the exact enable on which the interrupt rises. Some sweeps use sparse enables, with idle cycles between them, to show that only enables count. The short windows also make it cheap to run restarts from reads and from arrivals at the last enable before expiry, the read and enable in the same cycle, and re-entry from polled operation and from an empty FIFO.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

  localparam int unsigned MIN_DATA_BITS  = 5;
  localparam int unsigned DSEL_W         = 2;
  localparam int unsigned MAX_FRAME_BITS = 1 + MIN_DATA_BITS + (2**DSEL_W - 1) + 1 + 2;

  typedef struct packed {
    logic [DSEL_W-1:0] data_sel;
    logic              parity_on;
    logic              stop_two;
  } frame_fmt_t;

  // Bits on the line for one character: start, data, optional parity, stops.
  function automatic int unsigned frame_bits(frame_fmt_t f);
    return 1 + MIN_DATA_BITS + 32'(f.data_sel) + 32'(f.parity_on) + 1 + 32'(f.stop_two);
  endfunction

  // Idle window expressed in oversampled baud enables.
  function automatic int unsigned window_ticks(int unsigned fbits,
                                               int unsigned ovs,
                                               int unsigned chars);
    return fbits * ovs * chars;
  endfunction

endpackage

// File: rtl/rxto_window_calc.sv
module rxto_window_calc
  import rxto_pkg::*;
#(
  parameter int unsigned OVERSAMPLE   = 16,
  parameter int unsigned WINDOW_CHARS = 4,
  parameter int unsigned CNT_W        = 10
) (
  input  frame_fmt_t       fmt,
  output logic [CNT_W-1:0] win_ticks
);

  always_comb begin
    win_ticks = CNT_W'(window_ticks(frame_bits(fmt), OVERSAMPLE, WINDOW_CHARS));
  end

endmodule

// File: rtl/rxto_restart_ctrl.sv
module rxto_restart_ctrl (
  input  logic fifo_en,
  input  logic rx_avail_ie,
  input  logic fifo_nonempty,
  input  logic rx_char_done,
  input  logic host_rd,
  input  logic irq_q,
  output logic armed,
  output logic irq_clear,
  output logic tmr_restart
);

  always_comb begin
    armed       = fifo_en & rx_avail_ie;
    // Polled mode, empty FIFO or a host read all drop the request.
    irq_clear   = ~armed | ~fifo_nonempty | host_rd;
    // A new arrival restarts the window only before the request fires.
    tmr_restart = irq_clear | (rx_char_done & ~irq_q);
  end

endmodule

// File: rtl/rxto_idle_timer.sv
module rxto_idle_timer #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             baud_en,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             window_hit
);

  logic [CNT_W:0] cnt_next_ext;

  always_comb begin
    cnt_next_ext = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
    window_hit   = baud_en & ~restart & (cnt_next_ext >= {1'b0, limit});
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (baud_en && (cnt < limit)) begin
      cnt <= cnt_next_ext[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/rxto_top.sv
module rxto_top
  import rxto_pkg::*;
#(
  parameter int unsigned OVERSAMPLE   = 16,
  parameter int unsigned WINDOW_CHARS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                baud_en,
  input  logic                fifo_en,
  input  logic                rx_avail_ie,
  input  logic [DSEL_W-1:0]   data_sel,
  input  logic                parity_on,
  input  logic                stop_two,
  input  logic                fifo_nonempty,
  input  logic                rx_char_done,
  input  logic                host_rd,
  output logic                tmo_irq
);

  localparam int unsigned MAX_TICKS = window_ticks(MAX_FRAME_BITS, OVERSAMPLE, WINDOW_CHARS);
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

  frame_fmt_t       fmt;
  logic [CNT_W-1:0] win_ticks;
  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             irq_clear;
  logic             tmr_restart;
  logic             window_hit;

  always_comb begin
    fmt.data_sel  = data_sel;
    fmt.parity_on = parity_on;
    fmt.stop_two  = stop_two;
  end

  rxto_window_calc #(
    .OVERSAMPLE  (OVERSAMPLE),
    .WINDOW_CHARS(WINDOW_CHARS),
    .CNT_W       (CNT_W)
  ) win_i (
    .fmt      (fmt),
    .win_ticks(win_ticks)
  );

  rxto_restart_ctrl ctl_i (
    .fifo_en      (fifo_en),
    .rx_avail_ie  (rx_avail_ie),
    .fifo_nonempty(fifo_nonempty),
    .rx_char_done (rx_char_done),
    .host_rd      (host_rd),
    .irq_q        (tmo_irq),
    .armed        (armed),
    .irq_clear    (irq_clear),
    .tmr_restart  (tmr_restart)
  );

  rxto_idle_timer #(
    .CNT_W(CNT_W)
  ) tmr_i (
    .clk       (clk),
    .rst       (rst),
    .baud_en   (baud_en),
    .restart   (tmr_restart),
    .limit     (win_ticks),
    .cnt       (cnt),
    .window_hit(window_hit)
  );

  always_ff @(posedge clk) begin
    if (rst || irq_clear) begin
      tmo_irq <= 1'b0;
    end else if (window_hit) begin
      tmo_irq <= 1'b1;
    end
  end

endmodule

// File: rtl/rxto_checker.sv
module rxto_checker #(
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned MAX_TICKS = 768
) (
  input logic             clk,
  input logic             rst,
  input logic             baud_en,
  input logic             fifo_en,
  input logic             rx_avail_ie,
  input logic             fifo_nonempty,
  input logic             rx_char_done,
  input logic             host_rd,
  input logic             tmo_irq,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] win_ticks,
  input logic             tmr_restart
);

  AST_RST_CLEARS: assert property (@(posedge clk) rst |=> (!tmo_irq && cnt == '0)); // R1

  AST_RISE_AT_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo_irq) |-> ($past(baud_en) && ({1'b0, $past(cnt)} + 1'b1 >= {1'b0, $past(win_ticks)}))); // R2

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    32'(cnt) <= MAX_TICKS); // R2

  AST_EMPTY_LOW: assert property (@(posedge clk) disable iff (rst)
    !fifo_nonempty |=> (!tmo_irq && cnt == '0)); // R3

  AST_RX_RESTART: assert property (@(posedge clk) disable iff (rst)
    (rx_char_done && !tmo_irq) |=> (cnt == '0 && !tmo_irq)); // R4

  AST_READ_RESTART: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> cnt == '0); // R5

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (tmo_irq && !host_rd && fifo_nonempty && fifo_en && rx_avail_ie) |=> tmo_irq); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> !tmo_irq); // R7

  AST_POLLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en || !rx_avail_ie) |=> (!tmo_irq && cnt == '0)); // R8

  AST_ONLY_ENABLES_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!baud_en && !tmr_restart) |=> $stable(cnt)); // R9

endmodule

bind rxto_top rxto_checker #(
  .CNT_W    (CNT_W),
  .MAX_TICKS(MAX_TICKS)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .baud_en      (baud_en),
  .fifo_en      (fifo_en),
  .rx_avail_ie  (rx_avail_ie),
  .fifo_nonempty(fifo_nonempty),
  .rx_char_done (rx_char_done),
  .host_rd      (host_rd),
  .tmo_irq      (tmo_irq),
  .cnt          (cnt),
  .win_ticks    (win_ticks),
  .tmr_restart  (tmr_restart)
);

// File: tb/rxto_top_tb.sv
module rxto_top_tb_top;

  localparam int OVS = 2;
  localparam int WCH = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_en = 1'b0;
  logic       fifo_en = 1'b1;
  logic       rx_avail_ie = 1'b1;
  logic [1:0] data_sel = 2'd0;
  logic       parity_on = 1'b0;
  logic       stop_two = 1'b0;
  logic       fifo_nonempty = 1'b1;
  logic       rx_char_done = 1'b0;
  logic       host_rd = 1'b0;
  logic       tmo_irq;

  int checks = 0;
  int fails  = 0;

  rxto_top #(.OVERSAMPLE(OVS), .WINDOW_CHARS(WCH)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .baud_en      (baud_en),
    .fifo_en      (fifo_en),
    .rx_avail_ie  (rx_avail_ie),
    .data_sel     (data_sel),
    .parity_on    (parity_on),
    .stop_two     (stop_two),
    .fifo_nonempty(fifo_nonempty),
    .rx_char_done (rx_char_done),
    .host_rd      (host_rd),
    .tmo_irq      (tmo_irq)
  );

  always #10 clk = ~clk;

  function automatic int exp_win();
    int bits;
    bits = 2 + 5 + int'(data_sel) + int'(parity_on) + int'(stop_two);
    return WCH * OVS * bits;
  endfunction

  task automatic check(input logic exp, input string tag);
    checks++;
    if (tmo_irq !== exp) begin
      fails++;
      $display("FAIL %s: tmo_irq=%0b expected %0b (fmt %0d/%0b/%0b)",
               tag, tmo_irq, exp, data_sel, parity_on, stop_two);
    end
  endtask

  task automatic step(input logic be, input logic rd, input logic rx);
    baud_en = be; host_rd = rd; rx_char_done = rx;
    @(posedge clk);
    @(negedge clk);
    baud_en = 1'b0; host_rd = 1'b0; rx_char_done = 1'b0;
  endtask

  task automatic run_en(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0, 1'b0);
      for (int g = 0; g < gap; g++) step(1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic window_test(input string tag, input int gap);
    run_en(exp_win() - 1, gap);
    check(1'b0, tag);
    run_en(1, gap);
    check(1'b1, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  initial begin
    @(negedge clk);
    check(1'b0, "R1");
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(1'b0, "R1");

    // R2 / R9: every frame format, some with idle cycles between enables
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 2; p++) begin
        for (int t = 0; t < 2; t++) begin
          data_sel = 2'(s); parity_on = 1'(p); stop_two = 1'(t);
          step(1'b0, 1'b1, 1'b0);
          if (s == 1) window_test("R9", 2);
          else        window_test("R2", 0);
          step(1'b0, 1'b1, 1'b0);
          check(1'b0, "R7");
        end
      end
    end

    data_sel = 2'd3; parity_on = 1'b1; stop_two = 1'b1;

    // R1: reset while the request is high
    step(1'b0, 1'b1, 1'b0);
    window_test("R2", 0);
    rst = 1'b1;
    step(1'b0, 1'b0, 1'b0);
    check(1'b0, "R1");
    rst = 1'b0;
    window_test("R1", 0);

    // R4: arrival one enable before expiry restarts the window
    step(1'b0, 1'b1, 1'b0);
    run_en(exp_win() - 1, 0);
    step(1'b0, 1'b0, 1'b1);
    check(1'b0, "R4");
    window_test("R4", 0);

    // R6: arrival after firing keeps the request
    step(1'b0, 1'b0, 1'b1);
    check(1'b1, "R6");
    run_en(5, 1);
    check(1'b1, "R6");

    // R7: read clears, full window needed again
    step(1'b0, 1'b1, 1'b0);
    check(1'b0, "R7");
    window_test("R7", 0);

    // R5: read before expiry, and read coinciding with an enable
    step(1'b0, 1'b1, 1'b0);
    run_en(exp_win() - 1, 0);
    step(1'b0, 1'b1, 1'b0);
    check(1'b0, "R5");
    window_test("R5", 0);
    step(1'b1, 1'b1, 1'b0);
    check(1'b0, "R5");
    window_test("R5", 0);

    // R3: empty FIFO drops the request and keeps the timer at zero
    fifo_nonempty = 1'b0;
    step(1'b0, 1'b0, 1'b0);
    check(1'b0, "R3");
    run_en(2 * exp_win(), 0);
    check(1'b0, "R3");
    fifo_nonempty = 1'b1;
    step(1'b0, 1'b0, 1'b1);
    window_test("R3", 0);

    // R8: FIFO disabled, then interrupt enable cleared
    fifo_en = 1'b0;
    step(1'b0, 1'b0, 1'b0);
    check(1'b0, "R8");
    run_en(2 * exp_win(), 0);
    check(1'b0, "R8");
    fifo_en = 1'b1;
    window_test("R8", 0);
    rx_avail_ie = 1'b0;
    step(1'b0, 1'b0, 1'b0);
    check(1'b0, "R8");
    run_en(2 * exp_win(), 0);
    check(1'b0, "R8");
    rx_avail_ie = 1'b1;
    data_sel = 2'd0; parity_on = 1'b0; stop_two = 1'b0;
    window_test("R8", 3);

    summary();
  end

endmodule